// File: doc/BRIEF.md
# PCI Slot Hotplug Register Block

This block keeps per-slot state for up to 32 PCI slots and gives firmware a four-word register window. Firmware uses the window to learn which slots hold a device, which are waiting to be removed, and which may be removed at all. The platform reports slot events on a strobe with a 5-bit slot number: a cold-plug at boot, a hot-add, or a hot-remove. Hot events raise a one-cycle pulse toward the general-purpose event status bit that is reserved for PCI hotplug. A firmware write to the eject word retires one pending removal. When the slot's device is removable, the block also emits a one-hot removal strobe for that slot, so that external logic can tear the device down.

The "up" word is not a stored latch. It is formed when read, as the present mask masked by the removable mask, so a re-read after an event produces a device check on every populated removable slot. A platform reset request first retires every pending removal, one slot per clock. It then rebuilds the present mask from a slot inventory input and the removable mask from a fixed-device mask. While this runs, a busy flag is high and the register window and event input are shut.

Top module: `slot_hotplug_regs`

## Requirements
- R1: A read of word 0 (byte offset 0x0) returns the present mask ANDed with the removable mask, bit n standing for slot n.
- R2: A read of word 1 (offset 0x4) returns the pending-removal mask. A read of word 2 (offset 0x8) returns zero. A read of word 3 (offset 0xC) returns the removable mask.
- R3: A write to word 2 acts only on the lowest set bit n of the written value and clears pending-removal bit n. If slot n is removable, its present bit is also cleared and remove_o equals 1<<n for the cycle after the write. If slot n is not removable, remove_o stays zero. A written value of zero changes nothing.
- R4: A hot-add event (ev_kind_i = 1) sets the slot's present bit and pulses gpe_set_o for the cycle after the event. The pending-removal mask is left unchanged.
- R5: A hot-remove event (ev_kind_i = 2) sets the slot's pending-removal bit and pulses gpe_set_o for the cycle after the event. The present mask is left unchanged.
- R6: A cold-plug event (ev_kind_i = 0) sets the slot's present bit and gpe_set_o stays low.
- R7: Writes to words 0, 1 and 3 have no effect. An access whose byte enables are not all four ones, or whose address is not word-aligned, is ignored on write and reads zero.
- R8: A plat_rst_i pulse starts a drain that retires pending removals lowest slot first, one per cycle, and gives each removable slot a removal strobe. One cycle after the last removal, the block loads the present mask from inventory_i and the removable mask from ~fixed_mask_i. busy_o stays high for k+1 cycles, where k is the number of pending slots.
- R9: While busy_o is high, reads return zero, and writes and slot events are ignored.
- R10: After rst_ni is released, busy_o is high for one cycle. Then the pending mask is zero, the present mask equals inventory_i and the removable mask equals ~fixed_mask_i.
- R11: Read data appears on reg_rdata_o in the cycle after the access and is zero in cycles that follow no valid read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| plat_rst_i | input | 1 | Platform reset request: drain and rebuild |
| fixed_mask_i | input | 32 | Slots whose device cannot be removed |
| inventory_i | input | 32 | Slots populated, used when rebuilding |
| ev_valid_i | input | 1 | Slot event strobe |
| ev_kind_i | input | 2 | 0 cold-plug, 1 hot-add, 2 hot-remove |
| ev_slot_i | input | 5 | Slot number of the event |
| reg_valid_i | input | 1 | Register access strobe |
| reg_write_i | input | 1 | 1 write, 0 read |
| reg_addr_i | input | 4 | Byte address in the window |
| reg_be_i | input | 4 | Byte enables |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, one cycle after the access |
| busy_o | output | 1 | Drain or rebuild in progress |
| gpe_set_o | output | 1 | Pulse that sets the PCI hotplug event status bit |
| remove_o | output | 32 | One-hot removal strobe |

## Verification
A fault in the present, removable or pending masks is held in state and shows nowhere until firmware reads the window. The bench therefore reads the affected words after every event and eject, and the error appears in the read data one cycle after that read. A wrong choice of slot in the eject path, or a wrong removability decision, shows on remove_o in the very cycle after the write or drain step. A drain sequencing error shows in the order and count of removal strobes and in how many cycles busy_o stays high.

// File: rtl/slot_hp_pkg.sv
package slot_hp_pkg;
  typedef enum logic [1:0] {
    EV_COLD   = 2'd0,
    EV_ADD    = 2'd1,
    EV_REMOVE = 2'd2
  } ev_kind_e;

  // word index = byte address [3:2]
  typedef enum logic [1:0] {
    SEL_UP    = 2'd0,
    SEL_DOWN  = 2'd1,
    SEL_EJECT = 2'd2,
    SEL_RMV   = 2'd3
  } reg_sel_e;

  typedef enum logic {
    ST_RUN   = 1'b0,
    ST_DRAIN = 1'b1
  } state_e;
endpackage

// File: rtl/slot_hp_lowbit.sv
module slot_hp_lowbit #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] vec_i,
  output logic [W-1:0] bit_o
);
  assign bit_o = vec_i & (~vec_i + W'(1));
endmodule

// File: rtl/slot_hp_decode.sv
module slot_hp_decode
  import slot_hp_pkg::*;
#(
  parameter int unsigned NSLOT  = 32,
  localparam int unsigned SLOT_W = $clog2(NSLOT)
) (
  input  logic              ev_valid_i,
  input  logic [1:0]        ev_kind_i,
  input  logic [SLOT_W-1:0] ev_slot_i,
  input  logic              accept_i,
  output logic [NSLOT-1:0]  set_present_o,
  output logic [NSLOT-1:0]  set_down_o,
  output logic              gpe_o
);
  logic [NSLOT-1:0] hit_add;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic hit;
    assign hit              = ev_valid_i && accept_i && (ev_slot_i == SLOT_W'(s));
    assign set_present_o[s] = hit && (ev_kind_i == EV_ADD || ev_kind_i == EV_COLD);
    assign hit_add[s]       = hit && (ev_kind_i == EV_ADD);
    assign set_down_o[s]    = hit && (ev_kind_i == EV_REMOVE);
  end

  assign gpe_o = |hit_add || |set_down_o;
endmodule

// File: rtl/slot_hp_rdmux.sv
module slot_hp_rdmux
  import slot_hp_pkg::*;
#(
  parameter int unsigned NSLOT  = 32,
  parameter int unsigned DATA_W = 32
) (
  input  reg_sel_e          sel_i,
  input  logic [NSLOT-1:0]  present_i,
  input  logic [NSLOT-1:0]  enable_i,
  input  logic [NSLOT-1:0]  down_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    unique case (sel_i)
      SEL_UP:    rdata_o[NSLOT-1:0] = present_i & enable_i;
      SEL_DOWN:  rdata_o[NSLOT-1:0] = down_i;
      SEL_RMV:   rdata_o[NSLOT-1:0] = enable_i;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/slot_hotplug_regs.sv
module slot_hotplug_regs
  import slot_hp_pkg::*;
#(
  parameter int unsigned NSLOT  = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned SLOT_W = $clog2(NSLOT),
  localparam int unsigned BE_W   = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              plat_rst_i,
  input  logic [NSLOT-1:0]  fixed_mask_i,
  input  logic [NSLOT-1:0]  inventory_i,
  input  logic              ev_valid_i,
  input  logic [1:0]        ev_kind_i,
  input  logic [SLOT_W-1:0] ev_slot_i,
  input  logic              reg_valid_i,
  input  logic              reg_write_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [BE_W-1:0]   reg_be_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              busy_o,
  output logic              gpe_set_o,
  output logic [NSLOT-1:0]  remove_o
);
  state_e           state_q, state_d;
  logic [NSLOT-1:0] present_q, present_d;
  logic [NSLOT-1:0] enable_q, enable_d;
  logic [NSLOT-1:0] down_q, down_d;
  logic [NSLOT-1:0] set_present, set_down, ej_src, ej_bit;
  logic [DATA_W-1:0] rd_mux;
  logic             busy, acc_ok, eject_req, drain_done, gpe_hit;
  reg_sel_e         sel;

  assign busy   = (state_q == ST_DRAIN);
  assign busy_o = busy;
  assign sel    = reg_sel_e'(reg_addr_i[3:2]);
  assign acc_ok = reg_valid_i && !busy && (reg_be_i == '1) &&
                  (reg_addr_i[1:0] == 2'b00) && ((reg_addr_i >> 4) == '0);
  assign eject_req  = acc_ok && reg_write_i && (sel == SEL_EJECT);
  assign drain_done = busy && (down_q == '0);

  // drain reuses the eject path on the pending mask
  assign ej_src = busy ? down_q : (eject_req ? reg_wdata_i[NSLOT-1:0] : '0);

  slot_hp_lowbit #(.W(NSLOT)) u_lowbit (
    .vec_i (ej_src),
    .bit_o (ej_bit)
  );

  slot_hp_decode #(.NSLOT(NSLOT)) u_decode (
    .ev_valid_i    (ev_valid_i),
    .ev_kind_i     (ev_kind_i),
    .ev_slot_i     (ev_slot_i),
    .accept_i      (!busy),
    .set_present_o (set_present),
    .set_down_o    (set_down),
    .gpe_o         (gpe_hit)
  );

  slot_hp_rdmux #(.NSLOT(NSLOT), .DATA_W(DATA_W)) u_rdmux (
    .sel_i     (sel),
    .present_i (present_q),
    .enable_i  (enable_q),
    .down_i    (down_q),
    .rdata_o   (rd_mux)
  );

  always_comb begin
    down_d    = (down_q & ~ej_bit) | set_down;
    present_d = (present_q & ~(ej_bit & enable_q)) | set_present;
    enable_d  = enable_q;
    state_d   = state_q;
    if (drain_done) begin
      present_d = inventory_i;
      enable_d  = ~fixed_mask_i;
      state_d   = ST_RUN;
    end else if (plat_rst_i && !busy) begin
      state_d = ST_DRAIN;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_DRAIN;
      present_q   <= '0;
      enable_q    <= '1;
      down_q      <= '0;
      reg_rdata_o <= '0;
      gpe_set_o   <= 1'b0;
      remove_o    <= '0;
    end else begin
      state_q     <= state_d;
      present_q   <= present_d;
      enable_q    <= enable_d;
      down_q      <= down_d;
      reg_rdata_o <= (acc_ok && !reg_write_i) ? rd_mux : '0;
      gpe_set_o   <= gpe_hit;
      remove_o    <= ej_bit & enable_q;
    end
  end
endmodule

// File: rtl/slot_hp_chk.sv
module slot_hp_chk #(
  parameter int unsigned NSLOT  = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ev_valid_i,
  input logic [1:0]        ev_kind_i,
  input logic              reg_valid_i,
  input logic              reg_write_i,
  input logic              busy_o,
  input logic              gpe_set_o,
  input logic [NSLOT-1:0]  remove_o,
  input logic [DATA_W-1:0] reg_rdata_o
);
  p_remove_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(remove_o));

  p_remove_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (remove_o != '0) |-> $past(busy_o || (reg_valid_i && reg_write_i)));

  p_gpe_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gpe_set_o |-> $past(ev_valid_i && !busy_o && ev_kind_i != 2'd0));

  p_busy_no_gpe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_o) |-> !gpe_set_o);

  p_busy_rdata_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_o) |-> (reg_rdata_o == '0));
endmodule

bind slot_hotplug_regs slot_hp_chk #(.NSLOT(NSLOT), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ev_valid_i  (ev_valid_i),
  .ev_kind_i   (ev_kind_i),
  .reg_valid_i (reg_valid_i),
  .reg_write_i (reg_write_i),
  .busy_o      (busy_o),
  .gpe_set_o   (gpe_set_o),
  .remove_o    (remove_o),
  .reg_rdata_o (reg_rdata_o)
);

// File: tb/sim_slot_hotplug_regs.sv
module sim_slot_hotplug_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        plat_rst = 1'b0;
  logic [31:0] fixed_mask = 32'h0000_0010;
  logic [31:0] inventory = 32'h0000_0011;
  logic        ev_valid = 1'b0;
  logic [1:0]  ev_kind = 2'd0;
  logic [4:0]  ev_slot = 5'd0;
  logic        reg_valid = 1'b0;
  logic        reg_write = 1'b0;
  logic [3:0]  reg_addr = 4'd0;
  logic [3:0]  reg_be = 4'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] rdata;
  logic        busy, gpe;
  logic [31:0] remove;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  slot_hotplug_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .plat_rst_i(plat_rst),
    .fixed_mask_i(fixed_mask), .inventory_i(inventory),
    .ev_valid_i(ev_valid), .ev_kind_i(ev_kind), .ev_slot_i(ev_slot),
    .reg_valid_i(reg_valid), .reg_write_i(reg_write), .reg_addr_i(reg_addr),
    .reg_be_i(reg_be), .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata),
    .busy_o(busy), .gpe_set_o(gpe), .remove_o(remove)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: read data lands after the edge following the request
  initial forever begin
    item_t it;
    @(posedge clk);
    #2;
    if (q.size() > 0) begin
      it = q.pop_front();
      chk(it.tag, rdata, it.exp);
    end
  end

  task automatic rd(input logic [3:0] a, input logic [3:0] be,
                    input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a; reg_be = be;
    q.push_back('{exp, tag});
    @(negedge clk);
    reg_valid = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_be = be; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic ev(input logic [1:0] k, input logic [4:0] s);
    @(negedge clk);
    ev_valid = 1'b1; ev_kind = k; ev_slot = s;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    total++; bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R11 reset rdata", rdata, 32'h0);
    chk("R4 reset gpe", {31'd0, gpe}, 32'h0);
    chk("R3 reset remove", remove, 32'h0);
    rst_n = 1'b1;
    chk("R10 busy after reset", {31'd0, busy}, 32'h1);
    rd(4'h0, 4'hF, 32'h0000_0001, "R10 R1 up after reset");
    chk("R10 busy cleared", {31'd0, busy}, 32'h0);
    rd(4'hC, 4'hF, 32'hFFFF_FFEF, "R2 removable");
    rd(4'h4, 4'hF, 32'h0, "R2 down empty");
    rd(4'h8, 4'hF, 32'h0, "R2 eject reads zero");

    ev(2'd1, 5'd7);
    chk("R4 hot-add gpe", {31'd0, gpe}, 32'h1);
    rd(4'h0, 4'hF, 32'h0000_0081, "R4 up after add");
    rd(4'h4, 4'hF, 32'h0, "R4 down untouched");

    ev(2'd0, 5'd9);
    chk("R6 cold-plug no gpe", {31'd0, gpe}, 32'h0);
    rd(4'h0, 4'hF, 32'h0000_0281, "R6 up after cold-plug");

    ev(2'd2, 5'd7);
    chk("R5 hot-remove gpe", {31'd0, gpe}, 32'h1);
    ev(2'd2, 5'd4);
    ev(2'd2, 5'd9);
    rd(4'h4, 4'hF, 32'h0000_0290, "R5 down mask");
    rd(4'h0, 4'hF, 32'h0000_0281, "R5 present untouched");

    wr(4'h8, 4'hF, 32'h0000_0290);
    chk("R3 fixed slot no strobe", remove, 32'h0);
    rd(4'h4, 4'hF, 32'h0000_0280, "R3 lowest bit only");
    wr(4'h8, 4'hF, 32'h0000_0280);
    chk("R3 strobe slot 7", remove, 32'h0000_0080);
    rd(4'h0, 4'hF, 32'h0000_0201, "R3 present cleared");
    rd(4'h4, 4'hF, 32'h0000_0200, "R3 down after eject");
    wr(4'h8, 4'hF, 32'h0);
    chk("R3 zero eject no strobe", remove, 32'h0);

    wr(4'h0, 4'hF, 32'hFFFF_FFFF);
    wr(4'hC, 4'hF, 32'h0);
    rd(4'h0, 4'hF, 32'h0000_0201, "R7 up write ignored");
    rd(4'hC, 4'hF, 32'hFFFF_FFEF, "R7 removable write ignored");
    wr(4'h8, 4'h3, 32'h0000_0200);
    chk("R7 partial eject no strobe", remove, 32'h0);
    wr(4'h9, 4'hF, 32'h0000_0200);
    chk("R7 unaligned eject no strobe", remove, 32'h0);
    rd(4'h4, 4'hF, 32'h0000_0200, "R7 down kept");
    rd(4'h6, 4'hF, 32'h0, "R7 unaligned read zero");
    rd(4'h4, 4'h1, 32'h0, "R7 narrow read zero");

    ev(2'd2, 5'd0);
    rd(4'h4, 4'hF, 32'h0000_0201, "R5 down before drain");

    fixed_mask = 32'h0000_0030;
    inventory  = 32'h0000_00F1;
    @(negedge clk);
    plat_rst = 1'b1;
    @(negedge clk);
    plat_rst = 1'b0;
    chk("R8 busy step0", {31'd0, busy}, 32'h1);
    chk("R8 no strobe step0", remove, 32'h0);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = 4'h0; reg_be = 4'hF;
    q.push_back('{32'h0, "R9 read while busy"});
    ev_valid = 1'b1; ev_kind = 2'd1; ev_slot = 5'd20;
    @(negedge clk);
    reg_valid = 1'b0; ev_valid = 1'b0;
    chk("R8 drain slot 0", remove, 32'h0000_0001);
    chk("R9 no gpe while busy", {31'd0, gpe}, 32'h0);
    chk("R8 busy step1", {31'd0, busy}, 32'h1);
    @(negedge clk);
    chk("R8 drain slot 9", remove, 32'h0000_0200);
    chk("R8 busy step2", {31'd0, busy}, 32'h1);
    @(negedge clk);
    chk("R8 busy released", {31'd0, busy}, 32'h0);
    chk("R8 no strobe at rebuild", remove, 32'h0);
    rd(4'h0, 4'hF, 32'h0000_00C1, "R8 R9 up rebuilt");
    rd(4'hC, 4'hF, 32'hFFFF_FFCF, "R8 removable rebuilt");
    rd(4'h4, 4'hF, 32'h0, "R8 down drained");

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule